// File: doc/BRIEF.md
# Variable-length synchronous serial transceiver

This block is a full-duplex, clock-synchronous serial port whose frame length can be set anywhere from one to eight bits. A host writes a word into a single-entry transmit buffer. The word moves into a transmit shift register and goes out on the serial data line. At the same time, a receive shift register gathers bits from the input line and hands each finished frame to a single-entry receive buffer. Words longer than eight bits are carried as successive frames. When the host refills the transmit buffer before the current frame ends, the next frame follows with no pause in the serial clock.

The serial clock is either generated internally from a reload value or taken from an input pin. With the internal clock, the half-period is `reload + 2` base-clock cycles. The external clock passes through a two-flop synchronizer and an edge detector. Data changes on the falling edge of the serial clock and is sampled on the rising edge. The clock rests high between frames. The host can invert the transmit and receive data lines on their own, and can choose whether the transmit interrupt marks the buffer-to-shifter move or the end of the frame. A receive interrupt marks each handoff into the receive buffer. An overrun flag records a frame that completes while the receive buffer is still unread.

The host interface is a plain strobe-based register port. Writes go to address 0 (control), address 1 (reload) and address 2 (transmit buffer). Reads come from address 0 (control), address 1 (reload), address 2 (receive buffer) and address 3 (status).

Top module: `varlen_sio`

## Requirements
- R1: The frame length is control bits [10:8] plus one (1 to 8). Each frame shifts exactly that many bits, and received bits above the frame length read as 0 at address 2 (receive buffer in bits [7:0]).
- R2: Bits shift least-significant first. Control bit 4 selects most-significant first, but only when the frame length is 8; at any shorter length bit 4 is ignored and the order stays least-significant first.
- R3: With the internal clock (control bit 2 = 0), the serial clock `sclk_out` toggles every `reload + 2` base cycles while a frame runs. A frame's first edge is falling. It rests high when no frame runs.
- R4: The reload register (address 1, read back at address 1) resets to 0x0001. It accepts only 0x0001 to 0xFFFD; a write of any other value leaves it unchanged.
- R5: With control bit 2 = 1, frames are clocked by the edges of `sclk_in`, and `sclk_out` stays high.
- R6: A frame starts only when transmit enable (control bit 0) is 1 and the transmit buffer holds a written word (status bit 1). The frame is received only if receive enable (control bit 1) is 1 when it starts; otherwise no receive interrupt is raised and the receive buffer is unchanged.
- R7: If the transmit buffer is full at the last rising edge of a frame, the next frame loads at once and its first falling edge follows a half-period later, with no idle gap.
- R8: `tx_irq` pulses for one cycle. With control bit 3 = 0 it pulses when the buffer word moves into the shifter. With bit 3 = 1 it pulses when the frame ends, in the same cycle as `rx_irq`.
- R9: `rx_irq` pulses for one cycle when a received frame is placed in the receive buffer. This sets status bit 2, and a read of address 2 clears it.
- R10: Status bit 0 (overrun) is set when a frame completes while status bit 2 is still set and the receive buffer is not being read in that cycle. A read of address 3 clears it, and a new overrun in the same cycle takes priority over the clear.
- R11: Control bit 5 inverts the level driven on `sd_out`, and control bit 6 inverts the level taken from `sd_in`.
- R12: After reset, status reads 0, the receive buffer reads 0, and both `sclk_out` and `sd_out` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe (enables read side effects) |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 16 | Host read data, combinational from rd_addr |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
Two functions can fall in one base-clock cycle. The first is a frame's completion, which hands its received word to the buffer. The second is the load of the following frame from a transmit buffer refilled in mid-frame. The bench provokes this by writing a second word as soon as status shows the transmit buffer empty. It judges the result by requiring exactly sixteen rising serial-clock edges, 93 base cycles from the first falling edge to the last rising edge at reload 1, and both words intact in order. The same boundary with the end-of-frame interrupt selected must put `tx_irq` and `rx_irq` in the same cycle.

// File: rtl/varlen_sio_pkg.sv
package varlen_sio_pkg;
  localparam int FRAME_MAX = 8;
  localparam int IDX_W     = $clog2(FRAME_MAX);

  // control register bit positions
  localparam int CB_TXEN  = 0;
  localparam int CB_RXEN  = 1;
  localparam int CB_EXT   = 2;
  localparam int CB_DONE  = 3;
  localparam int CB_MSB   = 4;
  localparam int CB_TXINV = 5;
  localparam int CB_RXINV = 6;
  localparam int CB_LEN   = 8;

  // status register bit positions
  localparam int SB_OVR    = 0;
  localparam int SB_TXFULL = 1;
  localparam int SB_RXFULL = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_DATA   = 2'd2,
    ADDR_STAT   = 2'd3
  } addr_e;
endpackage

// File: rtl/varlen_sio_clkgen.sv
module varlen_sio_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] reload,
  input  logic             sclk_ext,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             sclk_int
);
  localparam int SYNC_W = 3;

  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic [SYNC_W-1:0] ext_q, ext_d;
  logic              int_run, tick, ext_fall, ext_rise;
  logic [DIV_W-1:0]  half_last;

  always_comb begin
    int_run   = run && !ext_mode;
    half_last = reload + DIV_W'(1);
    tick      = int_run && (cnt_q == half_last);
    cnt_d     = int_run ? (tick ? '0 : cnt_q + DIV_W'(1)) : '0;
    sclk_d    = int_run ? (tick ? ~sclk_q : sclk_q) : 1'b1;
    ext_d     = {ext_q[SYNC_W-2:0], sclk_ext};
    ext_fall  = ext_q[SYNC_W-1] && !ext_q[SYNC_W-2];
    ext_rise  = !ext_q[SYNC_W-1] && ext_q[SYNC_W-2];
    fall_evt  = run && (ext_mode ? ext_fall : (tick && sclk_q));
    rise_evt  = run && (ext_mode ? ext_rise : (tick && !sclk_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      ext_q  <= '1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      ext_q  <= ext_d;
    end
  end

  assign sclk_int = sclk_q;
endmodule

// File: rtl/varlen_sio_engine.sv
module varlen_sio_engine
  import varlen_sio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_evt,
  input  logic                 rise_evt,
  input  logic                 tx_en,
  input  logic                 rx_en,
  input  logic [IDX_W-1:0]     len_m1,
  input  logic                 msb_req,
  input  logic                 irq_on_done,
  input  logic [FRAME_MAX-1:0] tbuf,
  input  logic                 tbuf_full,
  input  logic                 din,
  output logic                 take,
  output logic                 busy,
  output logic                 txd,
  output logic                 tx_irq,
  output logic                 rx_push,
  output logic [FRAME_MAX-1:0] rx_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_MAX - 1);

  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     idx_q, idx_d, flen_q, flen_d, pos;
  logic                 fmsb_q, fmsb_d, ract_q, ract_d;
  logic [FRAME_MAX-1:0] tbits_q, tbits_d, rbits_q, rbits_d, rbits_cap;
  logic                 txd_q, txd_d, txirq_q, txirq_d, push_q, push_d;
  logic [FRAME_MAX-1:0] word_q, word_d;
  logic                 last_rise;

  always_comb begin
    pos       = fmsb_q ? (LAST_IDX - idx_q) : idx_q;
    last_rise = busy_q && rise_evt && (idx_q == flen_q);
    take      = tx_en && tbuf_full && (!busy_q || last_rise);
    rbits_cap = rbits_q;
    if (busy_q && rise_evt && ract_q) rbits_cap[pos] = din;

    busy_d  = busy_q;  idx_d  = idx_q;  flen_d = flen_q; fmsb_d = fmsb_q;
    tbits_d = tbits_q; rbits_d = rbits_q; ract_d = ract_q; txd_d = txd_q;
    word_d  = word_q;  txirq_d = 1'b0;  push_d = 1'b0;

    if (busy_q && fall_evt) txd_d = tbits_q[pos];
    if (busy_q && rise_evt) begin
      idx_d   = idx_q + IDX_W'(1);
      rbits_d = rbits_cap;
    end
    if (last_rise) begin
      busy_d  = 1'b0;
      push_d  = ract_q;
      word_d  = rbits_cap;
      txirq_d = irq_on_done;
    end
    if (take) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      flen_d  = len_m1;
      fmsb_d  = msb_req && (len_m1 == LAST_IDX);
      tbits_d = tbuf;
      ract_d  = rx_en;
      rbits_d = '0;
      if (!irq_on_done) txirq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; idx_q <= '0; flen_q <= '0; fmsb_q <= 1'b0;
      tbits_q <= '0; rbits_q <= '0; ract_q <= 1'b0; txd_q <= 1'b1;
      txirq_q <= 1'b0; push_q <= 1'b0; word_q <= '0;
    end else begin
      busy_q <= busy_d; idx_q <= idx_d; flen_q <= flen_d; fmsb_q <= fmsb_d;
      tbits_q <= tbits_d; rbits_q <= rbits_d; ract_q <= ract_d; txd_q <= txd_d;
      txirq_q <= txirq_d; push_q <= push_d; word_q <= word_d;
    end
  end

  assign busy    = busy_q;
  assign txd     = txd_q;
  assign tx_irq  = txirq_q;
  assign rx_push = push_q;
  assign rx_word = word_q;
endmodule

// File: rtl/varlen_sio.sv
module varlen_sio
  import varlen_sio_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [HOST_W-1:0] rd_data,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam logic [DIV_W-1:0]  RLD_MIN   = DIV_W'(1);
  localparam logic [DIV_W-1:0]  RLD_MAX   = DIV_W'((2 ** DIV_W) - 3);
  localparam logic [HOST_W-1:0] CTRL_MASK = HOST_W'(16'h077F);

  logic [1:0]           rst_pipe;
  logic                 rst_i;
  logic [HOST_W-1:0]    ctrl_q, ctrl_d;
  logic [DIV_W-1:0]     reload_q, reload_d;
  logic [FRAME_MAX-1:0] tbuf_q, tbuf_d, rbuf_q, rbuf_d, rx_word;
  logic                 tbuf_full_q, tbuf_full_d, rbuf_full_q, rbuf_full_d;
  logic                 ovr_q, ovr_d;
  logic [1:0]           din_q;
  logic                 wr_ctrl, wr_rld, wr_tx, rd_rx, rd_stat;
  logic                 take, eng_busy, txd, rx_push, fall_evt, rise_evt;
  logic                 irq_done, din;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  assign irq_done = ctrl_q[CB_DONE];
  assign din      = din_q[1] ^ ctrl_q[CB_RXINV];

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    wr_rld  = wr_en && (wr_addr == ADDR_RELOAD);
    wr_tx   = wr_en && (wr_addr == ADDR_DATA);
    rd_rx   = rd_en && (rd_addr == ADDR_DATA);
    rd_stat = rd_en && (rd_addr == ADDR_STAT);

    ctrl_d   = wr_ctrl ? (wr_data & CTRL_MASK) : ctrl_q;
    reload_d = reload_q;
    if (wr_rld && wr_data[DIV_W-1:0] >= RLD_MIN && wr_data[DIV_W-1:0] <= RLD_MAX)
      reload_d = wr_data[DIV_W-1:0];

    tbuf_d      = wr_tx ? wr_data[FRAME_MAX-1:0] : tbuf_q;
    tbuf_full_d = wr_tx ? 1'b1 : (take ? 1'b0 : tbuf_full_q);

    rbuf_d      = rx_push ? rx_word : rbuf_q;
    rbuf_full_d = rx_push ? 1'b1 : (rd_rx ? 1'b0 : rbuf_full_q);

    ovr_d = ovr_q;
    if (rd_stat) ovr_d = 1'b0;
    if (rx_push && rbuf_full_q && !rd_rx) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0; reload_q <= RLD_MIN; tbuf_q <= '0; tbuf_full_q <= 1'b0;
      rbuf_q <= '0; rbuf_full_q <= 1'b0; ovr_q <= 1'b0; din_q <= 2'b11;
    end else begin
      ctrl_q <= ctrl_d; reload_q <= reload_d; tbuf_q <= tbuf_d;
      tbuf_full_q <= tbuf_full_d; rbuf_q <= rbuf_d; rbuf_full_q <= rbuf_full_d;
      ovr_q <= ovr_d; din_q <= {din_q[0], sd_in};
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL:   rd_data = ctrl_q;
      ADDR_RELOAD: rd_data = HOST_W'(reload_q);
      ADDR_DATA:   rd_data = HOST_W'(rbuf_q);
      default: begin
        rd_data[SB_OVR]    = ovr_q;
        rd_data[SB_TXFULL] = tbuf_full_q;
        rd_data[SB_RXFULL] = rbuf_full_q;
      end
    endcase
  end

  varlen_sio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_i), .run(eng_busy), .ext_mode(ctrl_q[CB_EXT]),
    .reload(reload_q), .sclk_ext(sclk_in), .fall_evt(fall_evt),
    .rise_evt(rise_evt), .sclk_int(sclk_out)
  );

  varlen_sio_engine u_eng (
    .clk(clk), .rst_n(rst_i), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .tx_en(ctrl_q[CB_TXEN]), .rx_en(ctrl_q[CB_RXEN]),
    .len_m1(ctrl_q[CB_LEN +: IDX_W]), .msb_req(ctrl_q[CB_MSB]),
    .irq_on_done(irq_done), .tbuf(tbuf_q), .tbuf_full(tbuf_full_q), .din(din),
    .take(take), .busy(eng_busy), .txd(txd), .tx_irq(tx_irq),
    .rx_push(rx_push), .rx_word(rx_word)
  );

  assign sd_out = txd ^ ctrl_q[CB_TXINV];
  assign rx_irq = rx_push;
endmodule

// File: rtl/varlen_sio_chk.sv
module varlen_sio_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_out,
  input logic             eng_busy,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             irq_done,
  input logic             tbuf_full,
  input logic             rbuf_full,
  input logic             ovr,
  input logic [DIV_W-1:0] reload
);
  localparam logic [DIV_W-1:0] RLD_MAX = DIV_W'((2 ** DIV_W) - 3);

  assert_idle_clock_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> sclk_out) else $error("serial clock low while idle");

  assert_push_fills_buffer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> rbuf_full) else $error("receive buffer not full after rx_irq");

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_irq && rbuf_full)) else $error("overrun without cause");

  assert_early_tx_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !irq_done) |-> $past(tbuf_full)) else $error("load irq without buffered word");

  assert_rx_only_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(eng_busy)) else $error("rx_irq outside a frame");

  always @(posedge clk) begin
    if (rst_n) begin
      assert_reload_range_R4: assert (reload != '0 && reload <= RLD_MAX)
        else $error("reload out of range");
    end
  end
endmodule

bind varlen_sio varlen_sio_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_i), .sclk_out(sclk_out), .eng_busy(eng_busy),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .irq_done(irq_done),
  .tbuf_full(tbuf_full_q), .rbuf_full(rbuf_full_q), .ovr(ovr_q), .reload(reload_q)
);

// File: tb/sim_varlen_sio.sv
module sim_varlen_sio;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 8;
  // {n[7:0], 2'b0, rxinv, txinv, msb, len_m1[2:0], data[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01_07A5, 24'h01_0F1E, 24'h01_0B3C, 24'h01_00FF,
    24'h01_1655, 24'h01_3796, 24'h01_220B, 24'h05_07C3
  };

  logic        clk, rst_n, wr_en, rd_en, sclk_in;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        sclk_out, sd_in, sd_out, tx_irq, rx_irq;

  int n_chk, n_fail, cyc;
  int tx_cnt, rx_cnt, tx_t, rx_t;
  int rise_cnt, fall_cnt, first_fall, last_rise, prev_rise, cap_n;
  logic [7:0] cap_word;
  logic       cap_inv;

  varlen_sio u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sd_in(sd_in), .sd_out(sd_out), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  assign sd_in = sd_out;  // loopback

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (tx_irq) begin tx_cnt++; tx_t = cyc; end
    if (rx_irq) begin rx_cnt++; rx_t = cyc; end
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge sclk_out) begin
    rise_cnt++; prev_rise = last_rise; last_rise = cyc;
    if (cap_n < 8) cap_word[cap_n] = sd_out ^ cap_inv;
    cap_n++;
  end

  always @(negedge sclk_out) begin
    if (fall_cnt == 0) first_fall = cyc;
    fall_cnt++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rise_cnt = 0; fall_cnt = 0; cap_n = 0; cap_word = '0;
    first_fall = 0; last_rise = 0; prev_rise = 0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_rx(input int target);
    int t = 0;
    while (rx_cnt < target && t < 5000) begin @(negedge clk); t++; end
    idle(1);
  endtask

  task automatic wait_tx_empty();
    logic [15:0] s;
    for (int k = 0; k < 50; k++) begin
      reg_rd(2'd3, s);
      if (!s[1]) break;
    end
  endtask

  function automatic logic [15:0] mk_ctrl(bit txe, bit rxe, bit ext, bit done,
                                         bit msb, bit ti, bit ri, logic [2:0] lm1);
    return {5'b0, lm1, 1'b0, ri, ti, msb, done, ext, rxe, txe};
  endfunction

  function automatic logic [7:0] bitrev(logic [7:0] v);
    for (int k = 0; k < 8; k++) bitrev[k] = v[7-k];
  endfunction

  initial begin
    logic [15:0] r;
    logic [7:0]  data, mask, exp_rx, exp_cap;
    logic [2:0]  lm1;
    logic        msb, ti, ri;
    int          tgt, rxc;
    n_chk = 0; n_fail = 0; cyc = 0; tx_cnt = 0; rx_cnt = 0; tx_t = 0; rx_t = 0;
    cap_inv = 1'b0; clear_mon();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0;
    wr_data = '0; sclk_in = 1'b1;
    idle(4); rst_n = 1'b1; idle(4);

    // R12 reset state
    reg_rd(2'd3, r); chk("R12", "status after reset", r, 0);
    reg_rd(2'd2, r); chk("R12", "rx buffer after reset", r, 0);
    chk("R12", "sclk_out after reset", sclk_out, 1);
    chk("R12", "sd_out after reset", sd_out, 1);

    // R4 reload range
    reg_rd(2'd1, r); chk("R4", "reload reset value", r, 16'h0001);
    reg_wr(2'd1, 16'h0000); reg_rd(2'd1, r); chk("R4", "reload 0 rejected", r, 16'h0001);
    reg_wr(2'd1, 16'hFFFD); reg_rd(2'd1, r); chk("R4", "reload FFFD accepted", r, 16'hFFFD);
    reg_wr(2'd1, 16'hFFFE); reg_rd(2'd1, r); chk("R4", "reload FFFE rejected", r, 16'hFFFD);

    // vector table: length, order, inversion (R1 R2 R11)
    for (int i = 0; i < NVEC; i++) begin
      data = VEC[i][7:0]; lm1 = VEC[i][10:8]; msb = VEC[i][11];
      ti = VEC[i][12]; ri = VEC[i][13];
      reg_wr(2'd0, mk_ctrl(1, 1, 0, 0, msb, ti, ri, lm1));
      reg_wr(2'd1, {8'h00, VEC[i][23:16]});
      clear_mon(); cap_inv = ti; tgt = rx_cnt + 1;
      reg_wr(2'd2, {8'h00, data});
      wait_rx(tgt);
      reg_rd(2'd2, r);
      mask    = 8'((9'd1 << (lm1 + 1)) - 1);
      exp_rx  = ((ti ^ ri) ? ~data : data) & mask;
      exp_cap = (msb && lm1 == 3'd7) ? bitrev(data) : (data & mask);
      chk("R1 R11", $sformatf("vector %0d received word", i), r, exp_rx);
      chk("R2", $sformatf("vector %0d line bit order", i), cap_word, exp_cap);
      chk("R1", $sformatf("vector %0d bit count", i), cap_n, lm1 + 1);
    end

    // R3 internal clock period and idle level
    reg_wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 3'd7));
    reg_wr(2'd1, 16'd3);
    clear_mon(); tgt = rx_cnt + 1;
    reg_wr(2'd2, 16'h005A); wait_rx(tgt); reg_rd(2'd2, r);
    chk("R3", "rise to rise period", last_rise - prev_rise, 10);
    chk("R3", "first fall to last rise", last_rise - first_fall, 75);
    chk("R3", "clock idles high", sclk_out, 1);

    // R8 transmit interrupt select
    reg_wr(2'd1, 16'd2);
    tgt = rx_cnt + 1; reg_wr(2'd2, 16'h0033); wait_rx(tgt); reg_rd(2'd2, r);
    chk("R8", "load irq well before end", (rx_t - tx_t) >= 60, 1);
    reg_wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 0, 3'd7));
    tgt = rx_cnt + 1; reg_wr(2'd2, 16'h00CC); wait_rx(tgt); reg_rd(2'd2, r);
    chk("R8", "done irq same cycle as rx_irq", rx_t - tx_t, 0);

    // R7 back-to-back frames
    reg_wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 3'd7));
    reg_wr(2'd1, 16'd1);
    clear_mon(); tgt = rx_cnt + 1;
    reg_wr(2'd2, 16'h003A); wait_tx_empty(); reg_wr(2'd2, 16'h00C5);
    wait_rx(tgt); reg_rd(2'd2, r); chk("R7", "first word", r, 16'h3A);
    wait_rx(tgt + 1); reg_rd(2'd2, r); chk("R7", "second word", r, 16'hC5);
    chk("R7", "rising edges over two frames", rise_cnt, 16);
    chk("R7", "no gap: first fall to last rise", last_rise - first_fall, 93);

    // R10 overrun
    tgt = rx_cnt + 1; reg_wr(2'd2, 16'h0011); wait_rx(tgt);
    reg_rd(2'd3, r); chk("R9 R10", "status after one unread frame", r, 16'h4);
    tgt = rx_cnt + 1; reg_wr(2'd2, 16'h0022); wait_rx(tgt);
    reg_rd(2'd3, r); chk("R10", "overrun set", r, 16'h5);
    reg_rd(2'd3, r); chk("R10", "overrun cleared by status read", r, 16'h4);
    reg_rd(2'd2, r); reg_rd(2'd3, r); chk("R9", "rx full cleared by data read", r, 16'h0);

    // R6 start conditions
    reg_wr(2'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 3'd7));
    clear_mon(); tgt = rx_cnt + 1;
    reg_wr(2'd2, 16'h0077); idle(100);
    chk("R6", "no clock without transmit enable", fall_cnt, 0);
    reg_rd(2'd3, r); chk("R6", "word held, nothing received", r, 16'h2);
    reg_wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 3'd7));
    wait_rx(tgt); reg_rd(2'd2, r); chk("R6", "frame runs once enabled", r, 16'h77);
    reg_wr(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 3'd7));
    clear_mon(); rxc = rx_cnt;
    reg_wr(2'd2, 16'h0042); wait_tx_empty(); idle(100);
    chk("R6", "transmit-only frame clocked", rise_cnt, 8);
    chk("R6", "no rx_irq with receive disabled", rx_cnt, rxc);
    reg_rd(2'd3, r); chk("R6", "rx buffer untouched", r, 16'h0);

    // R5 external clock
    reg_wr(2'd0, mk_ctrl(1, 1, 1, 0, 0, 0, 0, 3'd7));
    clear_mon(); tgt = rx_cnt + 1;
    reg_wr(2'd2, 16'h006D); idle(5);
    for (int b = 0; b < 8; b++) begin
      sclk_in = 1'b0; idle(20);
      sclk_in = 1'b1; idle(20);
    end
    idle(10);
    chk("R5", "sclk_out held high", fall_cnt, 0);
    chk("R5", "frame completed", rx_cnt, tgt);
    reg_rd(2'd2, r); chk("R5", "word on external clock", r, 16'h6D);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule